// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Table Walk

This block turns a 32-bit virtual address into a 35-bit physical address. The low 12 bits are the offset within a 4 KiB page and pass through unchanged. The upper 20 bits, the virtual page number, are looked up in a small fully associative buffer of recent translations. Each buffer entry holds a page number tag and a 23-bit frame number. When the lookup hits, the physical address appears in the same cycle the request is taken. No memory access is made.

When the lookup misses, the block reads one word from a flat page table in memory. The word's address is the table base plus four times the page number. If the word's top bit is set, its low 23 bits are the frame number. That frame is written into the buffer and returned with the response. If the top bit is clear, the response is marked as a page fault and nothing is cached.

Only one miss is handled at a time. A flush input empties the buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req` are 0. No page is cached, so the first access to any page misses.
- R2: A request taken (`req_valid` and `req_ready` both 1) whose page is cached gives `rsp_valid`=1 in that same cycle. In that cycle `rsp_paddr` = {cached frame, `req_vaddr[11:0]`}, `rsp_fault`=0, and no memory read is started. A request that misses gives no response in the cycle it is taken.
- R3: A miss raises `mem_req` for exactly one cycle, in the cycle after the request is taken. `mem_addr` = `pt_base` + `req_vaddr[31:12]`×4, modulo 2^32.
- R4: From the cycle after a miss is taken until the response cycle, `req_ready` is 0 and requests offered on the port are ignored. They give no response and no memory read.
- R5: In the cycle `mem_rvalid` is 1 during a walk, `rsp_valid` is 1. If `mem_rdata[31]` is 1, then `rsp_fault`=0 and `rsp_paddr` = {`mem_rdata[22:0]`, offset}. Bits 30:23 of the table word are ignored. The page then hits on later accesses.
- R6: If `mem_rdata[31]` is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0. The page is not cached, so the next access to it misses again.
- R7: The buffer has 8 entries, and fills go to entries in round-robin order starting at entry 0 after reset or flush. The ninth distinct fill overwrites the first. The other seven pages still hit.
- R8: One cycle with `flush`=1 empties the buffer and returns the round-robin order to entry 0. If a fill completes in that same cycle, the fill is dropped, but its response is still delivered.
- R9: `mem_rvalid` pulses that arrive while no walk is in progress are ignored. They give no response and change no cached state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | 32 | Byte address of page table entry 0 |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | 35 | Physical address, zero on fault |
| rsp_fault | output | 1 | Page fault: table entry not valid |
| mem_req | output | 1 | One-cycle page table read request |
| mem_addr | output | 32 | Page table word address |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Page table word |

## Verification
A stale or wrongly tagged buffer entry shows up in the request cycle itself. The symptom is a response with a wrong frame, or a hit where a miss and memory read were due. Lost valid bits or a misplaced fill show up one access later: a page that should hit instead raises `mem_req` one cycle after the request. A round-robin pointer that drifts is seen only after the ninth fill, when the wrong page misses. For that reason the bench refills all eight entries and then probes both the evicted page and a survivor.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 35;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PFN_W     = PA_W - OFF_W;
    localparam int PTE_W     = 32;
    localparam int PTE_VBIT  = 31;
    localparam int PTE_SHIFT = 2;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } xl_entry_t;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_FETCH = 2'd1,
        WK_WAIT  = 2'd2
    } walk_state_e;

    function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                   input logic [VPN_W-1:0] vpn);
        return base + VA_W'({vpn, {PTE_SHIFT{1'b0}}});
    endfunction

    function automatic logic pte_present(input logic [PTE_W-1:0] w);
        return w[PTE_VBIT];
    endfunction

    function automatic logic [PFN_W-1:0] pte_frame(input logic [PTE_W-1:0] w);
        return w[PFN_W-1:0];
    endfunction

endpackage

// File: rtl/tlbx_cam.sv
module tlbx_cam
    import tlbx_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int SLOT_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    input  logic              fill_en,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn
);

    xl_entry_t        ent [N_ENT];
    logic [N_ENT-1:0] match;
    logic [N_ENT-1:0] vbits;

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (rst || flush) begin
                ent[i].valid <= 1'b0;
            end else if (fill_en && fill_slot == SLOT_W'(i)) begin
                ent[i].valid <= 1'b1;
                ent[i].vpn   <= fill_vpn;
                ent[i].pfn   <= fill_pfn;
            end
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign vbits[g] = ent[g].valid;
        assign match[g] = ent[g].valid && (ent[g].vpn == lk_vpn);
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N_ENT; i++) begin
            lk_pfn = lk_pfn | (match[i] ? ent[i].pfn : '0);
        end
    end

    assign lk_hit = |match;

    // R7: fill only on miss keeps every page in at most one entry
    a_r7_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R8: a flush leaves nothing valid
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vbits == '0));

endmodule

// File: rtl/tlbx_rr.sv
module tlbx_rr #(
    parameter int N_ENT  = 8,
    parameter int SLOT_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              advance,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(N_ENT - 1);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slot <= '0;
        end else if (advance) begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    // R8: flush rewinds replacement order
    a_r8_rr_rewind: assert property (@(posedge clk) disable iff (rst)
        flush |=> (slot == '0));

    // R7: pointer moves only on a fill
    a_r7_rr_hold: assert property (@(posedge clk) disable iff (rst || flush)
        !advance |=> $stable(slot));

endmodule

// File: rtl/tlbx_walk.sv
module tlbx_walk
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VA_W-1:0]  pt_base,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [OFF_W-1:0] req_off,
    input  logic             lk_hit,
    input  logic [PFN_W-1:0] lk_pfn,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_req,
    output logic [VA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn
);

    walk_state_e      st;
    logic [VPN_W-1:0] cap_vpn;
    logic [OFF_W-1:0] cap_off;
    logic             accept;
    logic             hit_rsp;
    logic             done;
    logic             pte_ok;

    assign req_ready = (st == WK_IDLE);
    assign accept    = req_valid && req_ready;
    assign hit_rsp   = accept && lk_hit;
    assign done      = (st == WK_WAIT) && mem_rvalid;
    assign pte_ok    = pte_present(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= WK_IDLE;
            cap_vpn <= '0;
            cap_off <= '0;
        end else begin
            unique case (st)
                WK_IDLE: if (accept && !lk_hit) begin
                    st      <= WK_FETCH;
                    cap_vpn <= req_vpn;
                    cap_off <= req_off;
                end
                WK_FETCH: st <= WK_WAIT;
                WK_WAIT:  if (mem_rvalid) st <= WK_IDLE;
                default:  st <= WK_IDLE;
            endcase
        end
    end

    assign mem_req  = (st == WK_FETCH);
    assign mem_addr = entry_addr(pt_base, cap_vpn);

    always_comb begin
        rsp_valid = hit_rsp || done;
        rsp_fault = done && !pte_ok;
        if (hit_rsp) begin
            rsp_paddr = {lk_pfn, req_off};
        end else if (done && pte_ok) begin
            rsp_paddr = {pte_frame(mem_rdata), cap_off};
        end else begin
            rsp_paddr = '0;
        end
    end

    assign fill_en  = done && pte_ok && !flush;
    assign fill_vpn = cap_vpn;
    assign fill_pfn = pte_frame(mem_rdata);

    // R2: a cached page answers in the cycle it is taken
    a_r2_hit_now: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lk_hit) |-> (rsp_valid && !rsp_fault && !mem_req));

    // R3: a table read follows a missed request
    a_r3_read_after_miss: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> $past(req_valid && req_ready && !lk_hit));

    // R3: the read request is a single pulse
    a_r3_one_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R4: no new request is taken while a read is issued
    a_r4_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R6: a faulting response carries no address
    a_r6_fault_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

    // R5: a fill coincides with a good response
    a_r5_fill_rsp: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> (rsp_valid && !rsp_fault));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlbx_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [31:0]      pt_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    output logic             rsp_valid,
    output logic [34:0]      rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata
);

    localparam int SLOT_W = $clog2(N_ENT);

    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic              fill_en;
    logic [VPN_W-1:0]  fill_vpn;
    logic [PFN_W-1:0]  fill_pfn;
    logic [SLOT_W-1:0] fill_slot;
    logic [VPN_W-1:0]  req_vpn;
    logic [OFF_W-1:0]  req_off;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    tlbx_cam #(.N_ENT(N_ENT), .SLOT_W(SLOT_W)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_vpn    (req_vpn),
        .lk_hit    (lk_hit),
        .lk_pfn    (lk_pfn),
        .fill_en   (fill_en),
        .fill_slot (fill_slot),
        .fill_vpn  (fill_vpn),
        .fill_pfn  (fill_pfn)
    );

    tlbx_rr #(.N_ENT(N_ENT), .SLOT_W(SLOT_W)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .advance (fill_en),
        .slot    (fill_slot)
    );

    tlbx_walk u_walk (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .pt_base    (pt_base),
        .req_valid  (req_valid),
        .req_vpn    (req_vpn),
        .req_off    (req_off),
        .lk_hit     (lk_hit),
        .lk_pfn     (lk_pfn),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_pfn   (fill_pfn)
    );

    // R9: responses only come from a taken request or a walk in progress
    a_r9_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !req_ready) |-> mem_rvalid);

endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;

    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        rsp_valid;
    logic [34:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rv_model;
    logic        stray;

    int n_chk = 0;
    int n_bad = 0;
    int cnt   = 0;
    logic [31:0] lat_addr;

    always #5 clk = ~clk;

    tlb_xlate u0 (
        .clk(clk), .rst(rst), .flush(flush), .pt_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // page table contents: pages whose low nibble is F are absent
    function automatic logic [31:0] pte(input logic [19:0] vpn);
        logic [22:0] fr;
        fr = {3'b110, vpn} ^ 23'h05A5A5;
        return {(vpn[3:0] != 4'hF), 8'hA5, fr};
    endfunction

    function automatic logic [34:0] exp_pa(input logic [31:0] va);
        logic [31:0] w;
        w = pte(va[31:12]);
        return w[31] ? {w[22:0], va[11:0]} : 35'd0;
    endfunction

    assign mem_rvalid = rv_model | stray;

    always @(posedge clk) begin
        rv_model <= (cnt == 1);
        if (cnt == 1) mem_rdata <= pte(20'((lat_addr - BASE) >> 2));
        if (mem_req) begin
            cnt      <= 3;
            lat_addr <= mem_addr;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end
    end

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access; exp_hit says whether the page is expected cached
    task automatic access(input logic [31:0] va, input logic exp_hit,
                          input logic flush_at_rsp);
        logic [34:0] pa;
        logic        flt;
        logic        seen;
        pa  = exp_pa(va);
        flt = !pte(va[31:12])[31];
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        #1;
        check(req_ready == 1'b1, "R4 ready before access", 64'(req_ready), 64'd1);
        if (exp_hit) begin
            check(rsp_valid == 1'b1, "R2 hit rsp_valid", 64'(rsp_valid), 64'd1);
            check(rsp_paddr == pa, "R2 hit paddr", 64'(rsp_paddr), 64'(pa));
            check(rsp_fault == 1'b0 && mem_req == 1'b0, "R2 hit no fault/no read",
                  64'({rsp_fault, mem_req}), 64'd0);
            @(posedge clk); #1;
            req_valid = 1'b0;
        end else begin
            check(rsp_valid == 1'b0, "R2 miss no early rsp", 64'(rsp_valid), 64'd0);
            @(posedge clk); #1;
            req_vaddr = va ^ 32'h0001_0000;
            @(negedge clk);
            check(mem_req == 1'b1, "R3 read pulse", 64'(mem_req), 64'd1);
            check(mem_addr == BASE + {10'd0, va[31:12], 2'b00}, "R3 read addr",
                  64'(mem_addr), 64'(BASE + {10'd0, va[31:12], 2'b00}));
            check(req_ready == 1'b0, "R4 busy during walk", 64'(req_ready), 64'd0);
            seen = 1'b0;
            for (int k = 0; k < 20 && !seen; k++) begin
                @(negedge clk);
                if (mem_rvalid) begin
                    seen = 1'b1;
                    check(rsp_valid == 1'b1, "R5 walk rsp_valid", 64'(rsp_valid), 64'd1);
                    check(rsp_fault == flt, "R6 fault flag", 64'(rsp_fault), 64'(flt));
                    check(rsp_paddr == pa, "R5 walk paddr", 64'(rsp_paddr), 64'(pa));
                    if (flush_at_rsp) flush = 1'b1;
                end else begin
                    check(rsp_valid == 1'b0 && mem_req == 1'b0,
                          "R4 ignored request during walk",
                          64'({rsp_valid, mem_req}), 64'd0);
                end
            end
            check(seen, "R5 walk completes", 64'(seen), 64'd1);
            @(posedge clk); #1;
            req_valid = 1'b0;
            flush     = 1'b0;
        end
    endtask

    // stimulus table: {vaddr, expected cached}
    localparam logic [32:0] VEC [9] = '{
        {32'h0000_1234, 1'b0},
        {32'h0000_1ABC, 1'b1},
        {32'h0000_F000, 1'b0},
        {32'h0000_F004, 1'b0},
        {32'h8765_4321, 1'b0},
        {32'h8765_4FFF, 1'b1},
        {32'hFFFF_E010, 1'b0},
        {32'hFFFF_E000, 1'b1},
        {32'h0000_1000, 1'b1}
    };

    initial begin
        rst = 1'b1; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
        stray = 1'b0; mem_rdata = '0; rv_model = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0 && mem_req == 1'b0, "R1 reset idle outputs",
              64'({rsp_valid, mem_req}), 64'd0);

        // table walk: R1 first miss, R2 hits, R3/R5 refills, R6 faults repeat
        for (int i = 0; i < 9; i++) begin
            access(VEC[i][32:1], VEC[i][0], 1'b0);
        end

        // R9: stray read data while idle
        @(negedge clk);
        stray = 1'b1;
        #1;
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 stray data ignored",
              64'({rsp_valid, req_ready}), 64'd1);
        @(posedge clk); #1 stray = 1'b0;
        access(32'h8765_4000, 1'b1, 1'b0);
        access(32'h0000_3000, 1'b0, 1'b0);

        // R8: flush while idle
        @(negedge clk); flush = 1'b1;
        @(posedge clk); #1 flush = 1'b0;
        access(32'h0000_1000, 1'b0, 1'b0);
        access(32'h0000_1004, 1'b1, 1'b0);

        // R8: flush in the same cycle as a fill drops the fill
        access(32'h0000_5000, 1'b0, 1'b1);
        access(32'h0000_5000, 1'b0, 1'b0);
        access(32'h0000_5000, 1'b1, 1'b0);

        // R7: round-robin eviction after a flush
        @(negedge clk); flush = 1'b1;
        @(posedge clk); #1 flush = 1'b0;
        for (int k = 0; k < 8; k++) access({20'h00100 + 20'(k), 12'h0}, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) access({20'h00100 + 20'(k), 12'h8}, 1'b1, 1'b0);
        access(32'h0010_8000, 1'b0, 1'b0);
        access(32'h0010_0000, 1'b0, 1'b0);
        access(32'h0010_2000, 1'b1, 1'b0);
        access(32'h0010_8000, 1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule